// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

The block takes one 21-bit display word per pixel clock and sends it out on three serial data lanes. Each lane carries seven bits per pixel period. A fourth lane carries a clock shape that is framed the same way, so a receiver can find the slot boundaries. The word holds 18 colour bits and three timing bits. The block uses two clocks: the pixel clock, and a bit clock that runs seven times faster and is phase-locked to it. The lane outputs are single-ended and feed external differential drivers.

One static input picks the pixel-clock edge on which the word is captured. The block watches for pixel-clock edges in the bit-clock domain. If no edge arrives within a set number of bit cycles, it forces every lane low. It starts sending again only after a run of good edges. An active-low power-down input goes through a pulse-width filter. A long enough low puts the block in its inactive state, with all lanes held low. A shorter glitch changes nothing.

Top module: `disp_ser7_top`

## Requirements
- R1: Word layout: colour bits are `pix_word[17:0]`, line sync is bit 18, frame sync is bit 19 and data-enable is bit 20. Lane k (k = 0, 1, 2) carries bits 7k to 7k+6 of every captured word.
- R2: Within a lane the lowest-numbered bit goes out first, one bit per bit-clock cycle. Slot 0 shows on the outputs after the third bit-clock rising edge that follows the capture edge.
- R3: Over slots 0 to 6, `clk_lane_q` carries 1,1,0,0,0,1,1. It is slot-aligned with the data lanes and restarts at the same edge as the data.
- R4: With `fall_sel` = 0 the word is captured on the rising pixel-clock edge. With `fall_sel` = 1 it is captured on the falling edge.
- R5: If `LOSS_CYC` (16) bit-clock cycles pass with no captured pixel-clock edge, all four lanes go to 0.
- R6: After a loss, output resumes at the `RECOVER_EDGES`-th (4th) pixel edge seen. That edge's word is sent in full.
- R7: If `pwr_n` stays low for `PD_MIN_CYC` bit cycles after its two-stage synchronizer, all lanes are held at 0. The clock monitor goes back to the missing state, so R6 applies when `pwr_n` returns high.
- R8: A `pwr_n` low pulse shorter than `PD_MIN_CYC` bit cycles has no effect on any lane.
- R9: The bit-clock domain reloads the lanes exactly once per captured pixel edge. Two reloads never happen on back-to-back bit cycles.
- R10: During and after reset, and until R6 is satisfied, all lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| bit_clk | input | 1 | Bit clock at seven times the pixel rate, phase-locked |
| rst_n | input | 1 | Asynchronous active-low reset |
| fall_sel | input | 1 | Static capture-edge select: 0 rising, 1 falling |
| pwr_n | input | 1 | Active-low power-down request |
| pix_word | input | 21 | Parallel display word |
| lane_q | output | 3 | Serial data lane bits |
| clk_lane_q | output | 1 | Forwarded clock lane bit |

## Verification
The bench drives walking-one, walking-zero and mixed words. It compares every lane bit against a behavioural model on every bit cycle. A wrong slot order, or a word loaded one cycle off, would scramble the bits in each frame. The bench stops the pixel clock to reach the loss threshold. A loss counter that is off by one, or a recovery that fires early, would emit a partial frame or stay silent one period too long. Power-down pulses are sent just below and well above the filter width. A missing filter would blank lanes on a short glitch. The run ends with falling-edge capture, which catches a capture edge taken from the wrong phase.

// File: rtl/disp_ser7_pkg.sv
package disp_ser7_pkg;
  localparam int unsigned LANES  = 3;
  localparam int unsigned SLOTS  = 7;
  localparam int unsigned WORD_W = LANES * SLOTS;
  // slot i of the clock lane is bit i: 1,1,0,0,0,1,1
  localparam logic [SLOTS-1:0] CLK_SHAPE = 7'b1100011;
  typedef logic [SLOTS-1:0] slot_vec_t;
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/ser_capture.sv
module ser_capture #(
  parameter int unsigned W = 21
) (
  input  logic         pix_clk,
  input  logic         rst_n,
  input  logic         fall_sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_o,
  output logic         tog_o
);
  logic [W-1:0] rise_word_q, fall_word_q;
  logic         rise_tog_q, fall_tog_q;
  logic         rise_en, fall_en;

  assign rise_en = !fall_sel;
  assign fall_en = fall_sel;

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_word_q <= '0;
      rise_tog_q  <= 1'b0;
    end else if (rise_en) begin
      rise_word_q <= din;
      rise_tog_q  <= ~rise_tog_q;
    end
  end

  always_ff @(negedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_word_q <= '0;
      fall_tog_q  <= 1'b0;
    end else if (fall_en) begin
      fall_word_q <= din;
      fall_tog_q  <= ~fall_tog_q;
    end
  end

  assign word_o = fall_sel ? fall_word_q : rise_word_q;
  assign tog_o  = fall_sel ? fall_tog_q  : rise_tog_q;
endmodule

// File: rtl/ser_pd_filter.sv
module ser_pd_filter #(
  parameter int unsigned MIN_CYC = 613
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_n,
  output logic pd_act_o,
  output logic pwr_sync_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pd_q, pd_d;

  always_comb begin
    cnt_d = cnt_q;
    pd_d  = pd_q;
    if (s2_q) begin
      cnt_d = '0;
      pd_d  = 1'b0;
    end else if (cnt_q == CW'(MIN_CYC - 1)) begin
      pd_d  = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      cnt_q <= '0;
      pd_q  <= 1'b0;
    end else begin
      s1_q  <= pwr_n;
      s2_q  <= s1_q;
      cnt_q <= cnt_d;
      pd_q  <= pd_d;
    end
  end

  assign pd_act_o   = pd_q;
  assign pwr_sync_o = s2_q;
endmodule

// File: rtl/ser_clk_monitor.sv
module ser_clk_monitor #(
  parameter int unsigned LOSS_CYC      = 16,
  parameter int unsigned RECOVER_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_act,
  input  logic edge_seen,
  output logic missing_o
);
  localparam int unsigned GW = (LOSS_CYC > 1) ? $clog2(LOSS_CYC) : 1;
  localparam int unsigned EW = $clog2(RECOVER_EDGES + 1);

  logic [GW-1:0] gap_q, gap_d;
  logic [EW-1:0] good_q, good_d;
  logic          miss_q, miss_d;

  always_comb begin
    gap_d  = gap_q;
    good_d = good_q;
    miss_d = miss_q;
    if (pd_act) begin
      gap_d  = '0;
      good_d = '0;
      miss_d = 1'b1;
    end else if (edge_seen) begin
      gap_d = '0;
      if (miss_q) begin
        if (good_q == EW'(RECOVER_EDGES - 1)) begin
          miss_d = 1'b0;
          good_d = '0;
        end else begin
          good_d = good_q + 1'b1;
        end
      end
    end else if (gap_q == GW'(LOSS_CYC - 1)) begin
      miss_d = 1'b1;
      good_d = '0;
    end else begin
      gap_d = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      good_q <= '0;
      miss_q <= 1'b1;
    end else begin
      gap_q  <= gap_d;
      good_q <= good_d;
      miss_q <= miss_d;
    end
  end

  assign missing_o = miss_q;
endmodule

// File: rtl/ser_lane_shift.sv
module ser_lane_shift
  import disp_ser7_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [LANES-1:0]  lane_bit_o,
  output logic              clk_bit_o
);
  slot_vec_t ck_q, ck_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    slot_vec_t sr_q, sr_d;

    always_comb begin
      if (load) sr_d = word[k*SLOTS +: SLOTS];
      else      sr_d = {1'b0, sr_q[SLOTS-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
    end

    assign lane_bit_o[k] = sr_q[0];
  end

  always_comb begin
    if (load) ck_d = CLK_SHAPE;
    else      ck_d = {1'b0, ck_q[SLOTS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_q <= '0;
    else        ck_q <= ck_d;
  end

  assign clk_bit_o = ck_q[0];
endmodule

// File: rtl/disp_ser7_top.sv
module disp_ser7_top
  import disp_ser7_pkg::*;
#(
  parameter int unsigned LOSS_CYC      = 16,
  parameter int unsigned RECOVER_EDGES = 4,
  parameter int unsigned PD_MIN_CYC    = 613
) (
  input  logic              pix_clk,
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              fall_sel,
  input  logic              pwr_n,
  input  logic [WORD_W-1:0] pix_word,
  output logic [LANES-1:0]  lane_q,
  output logic              clk_lane_q
);
  logic              rst_b;
  logic [WORD_W-1:0] cap_word;
  logic              cap_tog;
  logic [2:0]        tog_sync_q;
  logic              edge_seen;
  logic              pd_act, pwr_sync, missing;
  logic [LANES-1:0]  lane_raw;
  logic              clk_raw;
  logic              out_en;

  ser_rst_sync u_rst (.clk(bit_clk), .arst_n(rst_n), .rst_n_o(rst_b));

  ser_capture #(.W(WORD_W)) u_cap (
    .pix_clk(pix_clk), .rst_n(rst_b), .fall_sel(fall_sel),
    .din(pix_word), .word_o(cap_word), .tog_o(cap_tog)
  );

  always_ff @(posedge bit_clk or negedge rst_b) begin
    if (!rst_b) tog_sync_q <= '0;
    else        tog_sync_q <= {tog_sync_q[1:0], cap_tog};
  end

  assign edge_seen = tog_sync_q[1] ^ tog_sync_q[2];

  ser_pd_filter #(.MIN_CYC(PD_MIN_CYC)) u_pd (
    .clk(bit_clk), .rst_n(rst_b), .pwr_n(pwr_n),
    .pd_act_o(pd_act), .pwr_sync_o(pwr_sync)
  );

  ser_clk_monitor #(.LOSS_CYC(LOSS_CYC), .RECOVER_EDGES(RECOVER_EDGES)) u_mon (
    .clk(bit_clk), .rst_n(rst_b), .pd_act(pd_act),
    .edge_seen(edge_seen), .missing_o(missing)
  );

  ser_lane_shift u_shift (
    .clk(bit_clk), .rst_n(rst_b), .load(edge_seen), .word(cap_word),
    .lane_bit_o(lane_raw), .clk_bit_o(clk_raw)
  );

  assign out_en     = !missing && !pd_act;
  assign lane_q     = out_en ? lane_raw : '0;
  assign clk_lane_q = out_en && clk_raw;
endmodule

// File: rtl/disp_ser7_chk.sv
module disp_ser7_chk (
  input logic       bit_clk,
  input logic       rst_b,
  input logic       pd_act,
  input logic       pwr_sync,
  input logic       missing,
  input logic       edge_seen,
  input logic [2:0] lane_q,
  input logic       clk_lane_q
);
  // R7
  pd_quiet_chk: assert property (@(posedge bit_clk) disable iff (!rst_b)
    pd_act |-> (lane_q == 3'b000 && !clk_lane_q));
  // R7
  pd_exit_chk: assert property (@(posedge bit_clk) disable iff (!rst_b)
    (pd_act && pwr_sync) |=> !pd_act);
  // R8
  pd_filter_chk: assert property (@(posedge bit_clk) disable iff (!rst_b)
    $rose(pd_act) |-> $past(!pwr_sync));
  // R5
  loss_quiet_chk: assert property (@(posedge bit_clk) disable iff (!rst_b)
    missing |-> (lane_q == 3'b000 && !clk_lane_q));
  // R6
  recover_chk: assert property (@(posedge bit_clk) disable iff (!rst_b)
    $fell(missing) |-> $past(edge_seen));
  // R9
  single_load_chk: assert property (@(posedge bit_clk) disable iff (!rst_b)
    edge_seen |=> !edge_seen);
endmodule

bind disp_ser7_top disp_ser7_chk chk_i (
  .bit_clk(bit_clk), .rst_b(rst_b), .pd_act(pd_act), .pwr_sync(pwr_sync),
  .missing(missing), .edge_seen(edge_seen), .lane_q(lane_q),
  .clk_lane_q(clk_lane_q)
);

// File: tb/disp_ser7_top_tb_top.sv
module disp_ser7_top_tb_top;
  localparam int PDMIN = 40;
  localparam int LOSS  = 16;
  localparam int RECOV = 4;

  logic        pix_clk, bit_clk, rst_n, fall_sel, pwr_n;
  logic [20:0] pix_word;
  logic [2:0]  lane_q;
  logic        clk_lane_q;

  int    n_chk = 0, n_fail = 0;
  bit    pix_run = 0;
  int    ph = 6;
  int    n_word = 0;
  string tag = "R10";

  // behavioural model state
  logic [20:0] m_pend;
  int          m_ev = -1;
  int          m_gap, m_good, m_cnt;
  bit          m_miss, m_pd, m_p1, m_p2;
  logic [6:0]  m_sr [3];
  logic [6:0]  m_ck;

  disp_ser7_top #(.LOSS_CYC(LOSS), .RECOVER_EDGES(RECOV), .PD_MIN_CYC(PDMIN)) dut_i (
    .pix_clk(pix_clk), .bit_clk(bit_clk), .rst_n(rst_n), .fall_sel(fall_sel),
    .pwr_n(pwr_n), .pix_word(pix_word), .lane_q(lane_q), .clk_lane_q(clk_lane_q)
  );

  // 50 MHz bit clock; pixel clock = 4 high / 3 low bit periods, 2 ns after bit edge
  initial begin
    bit_clk = 0; pix_clk = 0;
    forever begin
      #10 bit_clk = 1;
      #2  ph = (ph + 1) % 7;
          pix_clk = pix_run && (ph < 4);
      #8  bit_clk = 0;
    end
  end

  function automatic logic [20:0] gen(int n);
    case (n % 3)
      0:       return 21'h1 << (n % 21);
      1:       return ~(21'h1 << (n % 21));
      default: return 21'(n * 21'h0A5A5) ^ 21'h15555;
    endcase
  endfunction

  // data driver and capture record (R4: selected edge)
  initial begin
    pix_word = gen(0);
    forever begin
      @(pix_clk);
      if (pix_clk != fall_sel && rst_n) begin
        m_pend = pix_word;
        m_ev   = 0;
        n_word++;
        #1 pix_word = gen(n_word);
      end
    end
  end

  // reference model, advanced on every bit clock rising edge
  always @(posedge bit_clk) begin
    bit ld, n_miss, n_pd;
    int n_gap, n_good, n_cnt;
    if (!rst_n) begin
      m_ev = -1; m_gap = 0; m_good = 0; m_cnt = 0;
      m_miss = 1; m_pd = 0; m_p1 = 1; m_p2 = 1; m_ck = 0;
      for (int k = 0; k < 3; k++) m_sr[k] = 0;
    end else begin
      ld = (m_ev == 2);
      if (m_ev >= 0 && m_ev < 3) m_ev++;
      n_cnt = m_cnt; n_pd = m_pd;
      if (m_p2) begin n_cnt = 0; n_pd = 0; end
      else if (m_cnt == PDMIN - 1) n_pd = 1;
      else n_cnt = m_cnt + 1;
      n_gap = m_gap; n_good = m_good; n_miss = m_miss;
      if (m_pd) begin n_gap = 0; n_good = 0; n_miss = 1; end
      else if (ld) begin
        n_gap = 0;
        if (m_miss) begin
          if (m_good == RECOV - 1) begin n_miss = 0; n_good = 0; end
          else n_good = m_good + 1;
        end
      end else if (m_gap == LOSS - 1) begin n_miss = 1; n_good = 0; end
      else n_gap = m_gap + 1;
      for (int k = 0; k < 3; k++)
        m_sr[k] = ld ? m_pend[7*k +: 7] : (m_sr[k] >> 1);
      m_ck = ld ? 7'b1100011 : (m_ck >> 1);
      m_cnt = n_cnt; m_pd = n_pd; m_gap = n_gap; m_good = n_good; m_miss = n_miss;
      m_p2 = m_p1; m_p1 = pwr_n;
    end
  end

  task automatic chk(string t, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", t, $time, act, exp);
    end
  endtask

  // every-cycle comparison, sampled at the falling edge
  always @(negedge bit_clk) begin
    logic [3:0] e;
    bit en;
    en = !m_miss && !m_pd && rst_n;
    e  = en ? {m_ck[0], m_sr[2][0], m_sr[1][0], m_sr[0][0]} : 4'b0;
    chk(tag, {clk_lane_q, lane_q}, e);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge bit_clk);
  endtask

  task automatic do_reset(bit sel);
    pix_run = 0;
    cyc(10);
    rst_n = 0; fall_sel = sel;
    cyc(4);
    chk("R10 reset", {clk_lane_q, lane_q}, 4'b0);
    rst_n = 1;
    cyc(30);
  endtask

  initial begin
    int ones;
    rst_n = 0; fall_sel = 0; pwr_n = 1;
    tag = "R10";
    do_reset(0);
    chk("R10 idle", {clk_lane_q, lane_q}, 4'b0);

    tag = "R6 R1 R2 R3 R9";
    pix_run = 1;
    cyc(7 * 40);
    // R3: four high slots out of seven
    ones = 0;
    for (int i = 0; i < 7; i++) begin ones += clk_lane_q; cyc(1); end
    chk("R3 clock shape", 4'(ones), 4'd4);

    tag = "R5";
    pix_run = 0;
    cyc(40);
    chk("R5 lost clock", {clk_lane_q, lane_q}, 4'b0);
    tag = "R6";
    pix_run = 1;
    cyc(7 * 20);

    tag = "R8";
    pwr_n = 0; cyc(PDMIN - 10); pwr_n = 1;
    cyc(7 * 10);

    tag = "R7";
    pwr_n = 0; cyc(PDMIN + 20);
    chk("R7 power-down", {clk_lane_q, lane_q}, 4'b0);
    pwr_n = 1;
    cyc(7 * 20);

    tag = "R4 R1 R2 R3";
    do_reset(1);
    pix_run = 1;
    cyc(7 * 40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule